// File: doc/BRIEF.md
# I2C Byte-Stream Slave

This block is a target device on a two-wire serial bus. It oversamples SCL and SDA with the core clock and turns them into START, STOP and clock-edge events. It compares the first byte after every START with a 7-bit device address. On a match it moves whole bytes between the bus and a local device as an unbroken stream, one byte per bus byte.

The ninth rising SCL edge of every byte closes the acknowledge slot, and the block does its work on that edge. On the address byte it decides between write mode, read mode and ignore mode. In write mode it fires a one-cycle write strobe that carries the received byte. In read mode it fires a read strobe that asks the local device for the next byte. A slow bus can therefore feed a fast local device, such as a display controller, a byte at a time.

SDA leaves the block only as an active-high pull-down enable for an open-drain pad. The block never drives the line high.

Top module: `i2c_stream_slave`

## Requirements
- R1: While reset is asserted and right after it is released, the pull-down enable and both strobes are low.
- R2: A START (SDA falling while SCL is high) returns the slave to address compare from any state, and any bits of a partly shifted byte are discarded.
- R3: The first byte after START is compared MSB first, with bits [7:1] as the address and bit 0 as the direction (0 = write to the slave, 1 = read from it). On a match the slave pulls SDA low for the ninth clock.
- R4: On an address mismatch the slave does not acknowledge. It never pulls SDA and fires no strobe until the next START.
- R5: In write mode each data byte is sampled MSB first on rising SCL edges and acknowledged with SDA low. On the ninth rising edge a one-cycle write strobe fires, with the byte on the write-data output.
- R6: On a read-direction address match, the ninth rising edge of the address byte fires a read strobe. The slave latches the read-data input one clock after that strobe and drives the byte MSB first, changing SDA after each falling SCL edge.
- R7: In read mode, a low SDA sampled in the acknowledge slot fires another read strobe and starts the next byte. A high SDA (NACK) fires no strobe, and SDA stays released until the next START.
- R8: A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released. SCL clocking that follows without a START produces no acknowledge and no strobe.
- R9: The pull-down enable changes only in the clock after a detected falling SCL edge, START or STOP, so SDA is stable throughout each SCL high phase.
- R10: Strobes last one clock, and the write strobe and the read strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High pulls SDA low through the open-drain pad |
| wr_data_o | output | 8 | Last byte received in write mode |
| wr_stb_o | output | 1 | One-cycle pulse that marks a new byte on wr_data_o |
| rd_data_i | input | 8 | Next byte to send, sampled one clock after rd_stb_o |
| rd_stb_o | output | 1 | One-cycle pulse that requests the next byte to send |

## Verification
On a read-direction address, the single ninth rising SCL edge both settles the address decision and issues the first read request. These two functions fall in the same cycle. The bench provokes this by addressing the slave for reading and counting read strobes right after the acknowledge clock. It then checks that the first byte shifted onto SDA is the value it supplied in answer to that very strobe. The same edge on a NACK must change mode without a strobe, and the bench judges this by the strobe count and by a released line during the clocks that follow.

// File: rtl/i2c_strm_pkg.sv
package i2c_strm_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_IGNORE,
    ST_HALT
  } slv_state_t;

  // Bus events produced by the line tracker, valid for one clock
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_tracker.sv
module i2c_line_tracker
  import i2c_strm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sync_q;
  logic [SYNC_STAGES-1:0] sda_sync_q;
  logic                   scl_prev_q;
  logic                   sda_prev_q;
  logic                   scl_s;
  logic                   sda_s;

  // Idle bus is high, so the chain resets to ones
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= scl_i;
          sda_sync_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
          sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sync_q[LAST];
  assign sda_s = sda_sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  // Conditions need SCL high on both samples around the SDA change
  always_comb begin
    evt.start    = scl_prev_q && scl_s && sda_prev_q && !sda_s;
    evt.stop     = scl_prev_q && scl_s && !sda_prev_q && sda_s;
    evt.scl_rise = !scl_prev_q && scl_s;
    evt.scl_fall = scl_prev_q && !scl_s;
    evt.sda      = sda_s;
  end

endmodule

// File: rtl/i2c_strm_ctrl.sv
module i2c_strm_ctrl
  import i2c_strm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_stb,
  output logic              rd_stb
);

  localparam int              CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  slv_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] wr_data_q, wr_data_d;
  logic              pull_q, pull_d;
  logic              wr_stb_q, wr_stb_d;
  logic              rd_stb_q, rd_stb_d;
  logic              addr_hit;
  logic              in_byte;

  assign addr_hit = (rx_q[BYTE_W-1:1] == DEV_ADDR);
  assign in_byte  = (state_q == ST_ADDR) || (state_q == ST_WRITE) ||
                    (state_q == ST_READ);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    wr_data_d = wr_data_q;
    pull_d    = pull_q;
    wr_stb_d  = 1'b0;
    rd_stb_d  = 1'b0;

    // Local device answers a read request one clock later
    if (rd_stb_q) tx_d = rd_data;

    if (evt.stop) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (evt.start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (evt.scl_rise && in_byte) begin
      if (cnt_q != ACK_SLOT) begin
        rx_d  = {rx_q[BYTE_W-2:0], evt.sda};
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        unique case (state_q)
          ST_ADDR: begin
            if (!addr_hit) begin
              state_d = ST_IGNORE;
            end else if (rx_q[0]) begin
              state_d  = ST_READ;
              rd_stb_d = 1'b1;
            end else begin
              state_d = ST_WRITE;
            end
          end
          ST_WRITE: begin
            wr_stb_d  = 1'b1;
            wr_data_d = rx_q;
          end
          ST_READ: begin
            if (evt.sda) state_d = ST_HALT;
            else         rd_stb_d = 1'b1;
          end
          default: state_d = state_q;
        endcase
      end
    end else if (evt.scl_fall) begin
      unique case (state_q)
        ST_ADDR:  pull_d = (cnt_q == ACK_SLOT) && addr_hit;
        ST_WRITE: pull_d = (cnt_q == ACK_SLOT);
        ST_READ: begin
          if (cnt_q != ACK_SLOT) begin
            pull_d = !tx_q[BYTE_W-1];
            tx_d   = {tx_q[BYTE_W-2:0], 1'b1};
          end else begin
            pull_d = 1'b0;
          end
        end
        default: pull_d = 1'b0;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '1;
      wr_data_q <= '0;
      pull_q    <= 1'b0;
      wr_stb_q  <= 1'b0;
      rd_stb_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      wr_data_q <= wr_data_d;
      pull_q    <= pull_d;
      wr_stb_q  <= wr_stb_d;
      rd_stb_q  <= rd_stb_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_data  = wr_data_q;
  assign wr_stb   = wr_stb_q;
  assign rd_stb   = rd_stb_q;

  // R2: START always re-enters address compare
  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.start && !evt.stop) |=> (state_q == ST_ADDR));

  // R4: ignore mode leaves the line alone
  p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!pull_q && !wr_stb_q && !rd_stb_q));

  // R5: write strobe is a single pulse
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_q |=> !wr_stb_q);

  // R7: after a NACK the line stays released
  p_halt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> !pull_q);

  // R8: STOP releases SDA and idles
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> (!pull_q && state_q == ST_IDLE));

  // R9: drive changes only after a falling SCL edge or a bus condition
  p_sda_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> $past(evt.scl_fall || evt.start || evt.stop));

  // R10: strobes never overlap
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb_q, rd_stb_q}));

endmodule

// File: rtl/i2c_stream_slave.sv
module i2c_stream_slave
  import i2c_strm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h3C,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_stb_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_stb_o
);

  bus_evt_t evt;

  i2c_line_tracker #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tracker (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_i(scl_i),
    .sda_i(sda_i),
    .evt  (evt)
  );

  i2c_strm_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .rd_data (rd_data_i),
    .sda_pull(sda_pull_o),
    .wr_data (wr_data_o),
    .wr_stb  (wr_stb_o),
    .rd_stb  (rd_stb_o)
  );

endmodule

// File: tb/i2c_stream_slave_test.sv
module i2c_stream_slave_test;

  localparam int         Q    = 6;
  localparam logic [6:0] ADDR = 7'h3C;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda;
  logic       sda_line;
  logic       sda_pull;
  logic [7:0] wr_data;
  logic       wr_stb;
  logic       rd_stb;
  logic [7:0] rd_data = 8'h00;

  int         n_cmp = 0;
  int         n_bad = 0;
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  int         rd_idx = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_src [4] = '{8'hC3, 8'h5E, 8'h77, 8'h00};
  logic [7:0] e_byte;
  logic       wr_prev = 1'b0;
  logic       rd_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  i2c_stream_slave #(.DEV_ADDR(ADDR)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_pull_o(sda_pull),
    .wr_data_o (wr_data),
    .wr_stb_o  (wr_stb),
    .rd_data_i (rd_data),
    .rd_stb_o  (rd_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  // One SCL pulse; returns the line level seen mid-high (R9 stability)
  task automatic clk_bit(input bit b, output bit seen);
    bit a;
    bit z;
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(1);
    a = sda_line; wq(Q - 1);
    seen = sda_line; wq(Q - 1);
    z = sda_line;
    chk((a == seen) && (z == seen), "R9", "SDA moved while SCL high",
        {a, z}, {seen, seen});
    wq(1);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(!ack, s);
  endtask

  // Scoreboard monitor and local-device model
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected write strobe", wr_data, 0);
        end else begin
          e_byte = exp_q.pop_front();
          chk(wr_data == e_byte, "R5", "write byte", wr_data, e_byte);
        end
      end
      if (rd_stb) begin
        rd_cnt++;
        rd_data = rd_src[rd_idx];
        if (rd_idx < 3) rd_idx++;
      end
      if (wr_stb || rd_stb)
        chk(!(wr_stb && rd_stb) && !(wr_stb && wr_prev) && !(rd_stb && rd_prev),
            "R10", "strobe overlap or stretch", {wr_stb, rd_stb}, 0);
      wr_prev = wr_stb;
      rd_prev = rd_stb;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit         a;
    int         c_wr;
    int         c_rd;
    logic [7:0] v;

    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    wq(5);
    chk(!sda_pull && !wr_stb && !rd_stb, "R1", "outputs in reset",
        {sda_pull, wr_stb, rd_stb}, 0);
    rst_n = 1'b1;
    wq(5);
    chk(!sda_pull && !wr_stb && !rd_stb, "R1", "outputs after reset",
        {sda_pull, wr_stb, rd_stb}, 0);

    // R3, R5: write stream
    exp_q.push_back(8'hA5);
    exp_q.push_back(8'h3C);
    exp_q.push_back(8'h00);
    exp_q.push_back(8'hFF);
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    chk(a, "R3", "address ack", a, 1);
    foreach (rd_src[i]) begin
      if (i < 1) begin end
    end
    send_byte(8'hA5, a); chk(a, "R5", "data ack A5", a, 1);
    send_byte(8'h3C, a); chk(a, "R5", "data ack 3C", a, 1);
    send_byte(8'h00, a); chk(a, "R5", "data ack 00", a, 1);
    send_byte(8'hFF, a); chk(a, "R5", "data ack FF", a, 1);
    bus_stop();
    wq(4 * Q);
    chk(exp_q.size() == 0, "R5", "bytes not delivered", exp_q.size(), 0);
    chk(wr_cnt == 4, "R5", "write strobe count", wr_cnt, 4);

    // R8: clocking after STOP without START
    c_wr = wr_cnt;
    c_rd = rd_cnt;
    send_byte({ADDR, 1'b0}, a);
    chk(!a, "R8", "ack after stop", a, 0);
    send_byte(8'h11, a);
    chk(!a, "R8", "data ack after stop", a, 0);
    chk(wr_cnt == c_wr && rd_cnt == c_rd, "R8", "strobes after stop",
        wr_cnt + rd_cnt, c_wr + c_rd);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(2 * Q);

    // R4: mismatching address
    bus_start();
    send_byte({7'h42, 1'b0}, a);
    chk(!a, "R4", "ack on mismatch", a, 0);
    send_byte(8'h5A, a);
    chk(!a, "R4", "data ack while ignoring", a, 0);
    send_byte({ADDR, 1'b1}, a);
    chk(!a, "R4", "address byte mid-ignore", a, 0);
    chk(wr_cnt == c_wr && rd_cnt == c_rd, "R4", "strobes while ignoring",
        wr_cnt + rd_cnt, c_wr + c_rd);
    bus_stop();

    // R2: repeated START discards a partial byte
    exp_q.push_back(8'h81);
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    chk(a, "R2", "first address ack", a, 1);
    clk_bit(1'b1, a);
    clk_bit(1'b0, a);
    clk_bit(1'b1, a);
    clk_bit(1'b1, a);
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    chk(a, "R2", "address ack after restart", a, 1);
    send_byte(8'h81, a);
    chk(a, "R2", "data ack after restart", a, 1);
    bus_stop();
    wq(4 * Q);
    chk(wr_cnt == c_wr + 1, "R2", "single byte after restart", wr_cnt, c_wr + 1);
    chk(exp_q.size() == 0, "R2", "restart byte missing", exp_q.size(), 0);

    // R6, R7: read stream, address decision and first request share an edge
    c_rd = rd_cnt;
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    chk(a, "R6", "read address ack", a, 1);
    chk(rd_cnt == c_rd + 1, "R6", "request on address edge", rd_cnt, c_rd + 1);
    recv_byte(1'b1, v);
    chk(v == 8'hC3, "R6", "first read byte", v, 8'hC3);
    recv_byte(1'b1, v);
    chk(v == 8'h5E, "R7", "second read byte", v, 8'h5E);
    recv_byte(1'b0, v);
    chk(v == 8'h77, "R7", "last read byte", v, 8'h77);
    chk(rd_cnt == c_rd + 3, "R7", "requests before NACK", rd_cnt, c_rd + 3);
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R7", "line after NACK", v, 8'hFF);
    chk(rd_cnt == c_rd + 3, "R7", "request after NACK", rd_cnt, c_rd + 3);
    bus_stop();
    wq(4 * Q);
    chk(!sda_pull, "R8", "released after stop", sda_pull, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule